// File: doc/BRIEF.md
# I2C Master Receive Byte Engine

This block is the receive half of an I2C bus master. Once the addressing phase is over, the host starts each incoming word by reading the receive data register. The engine then clocks the configured number of bits in from SDA, most significant bit first. If acknowledge is enabled, it adds a ninth clock during which it pulls SDA low. When the word is in, it raises an interrupt and holds SCL low. This stalls the slave transmitter until the host reads the data and starts the next word.

The first read after addressing returns a value with no meaning; its only purpose is to start the first receive. To end a read burst, software works in four steps:

1. It clears acknowledge enable before it reads the word that comes before the final word, so the final word is clocked with no acknowledge pulse.
2. It sets the bit count to one and reads again. This starts a single clock, during which SDA stays released, and the transmitter takes that as a NACK.
3. It waits for that clock to complete.
4. It requests the stop condition.

The SCL low and high periods are each `HALF` system clocks, and `HALF` must be 2 or more. The pins are open drain. Each output is an active-high pull-down enable.

Top module: `i2c_mrx_engine`

## Requirements
- R1: After reset, neither SCL nor SDA is pulled low, busy and irq are 0, and rx_data is 0.
- R2: A `rd_strobe` pulse while idle or waiting starts a transfer. Bit-count value k (1..7) gives k SCL pulses and value 0 gives 8. One more pulse is added if `cfg_ack_en` was 1 at that strobe.
- R3: Data bits are taken from SDA at the end of each SCL low period, MSB first. When irq rises, `rx_data` holds them right-aligned, with the unused upper bits at 0.
- R4: During data pulses the engine leaves SDA released. During the acknowledge pulse it pulls SDA low. With acknowledge off, a 1-bit transfer leaves SDA high at its clock (NACK).
- R5: After the last pulse of a transfer, irq is 1 and SCL is held low until the next `rd_strobe` or `stop_req`. Either of these clears irq.
- R6: While busy, the SDA drive changes only in a cycle where SCL has been pulled low for this cycle and the one before.
- R7: Within a transfer, every SCL high period lasts exactly `HALF` cycles. Every low period except the first one of a transfer also lasts exactly `HALF` cycles.
- R8: A `stop_req` while waiting pulls SDA low at once with SCL still low. SCL is released `HALF` cycles later. SDA is released `HALF` cycles after that, in the same cycle busy falls. irq is 0 throughout the stop.
- R9: busy is 1 from the cycle a transfer starts until the stop completes, and SCL is never pulled low while busy is 0.
- R10: `rd_strobe` and `stop_req` during a running transfer or stop are ignored. `stop_req` while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | Host read of the receive data register |
| stop_req | input | 1 | Host request for a stop condition |
| cfg_bits | input | 3 | Bit count of the next word (0 means 8) |
| cfg_ack_en | input | 1 | Acknowledge enable for the next word |
| sda_in | input | 1 | Level of the SDA bus line |
| rx_data | output | 8 | Received word, right-aligned |
| irq | output | 1 | Word complete, SCL held low |
| busy | output | 1 | Bus owned by this engine |
| scl_low | output | 1 | Pull-down enable for SCL |
| sda_low | output | 1 | Pull-down enable for SDA |

## Verification
If the bit index is wrong, the pulse count is off at the next irq and `rx_data` shifts. This is visible within one word time. If the acknowledge flag latches the wrong value, SDA is wrong at the ninth rising SCL edge of that same word. If a phase counter is wrong, it shows up as a mismatched SCL period length at the very next SCL edge. If the stop sequencer is wrong, it shows up as wrong pin levels within `2*HALF` cycles of the request. Every bit count is swept with every data value, so a fault in the shift path shows up within one word.

// File: rtl/i2c_mrx_engine.sv
module i2c_mrx_engine #(
  parameter int HALF = 4,
  localparam int CW = $clog2(HALF + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_strobe,
  input  logic       stop_req,
  input  logic [2:0] cfg_bits,
  input  logic       cfg_ack_en,
  input  logic       sda_in,
  output logic [7:0] rx_data,
  output logic       irq,
  output logic       busy,
  output logic       scl_low,
  output logic       sda_low
);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_WAIT, S_STPA, S_STPB} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [3:0]    nbits;
  logic [3:0]    idx;
  logic          ack_q;
  logic [7:0]    sh;

  wire       cnt_end = (cnt == CW'(HALF - 1));
  wire       launch  = rd_strobe && (st == S_IDLE || st == S_WAIT);
  wire [3:0] len     = (cfg_bits == 3'd0) ? 4'd8 : {1'b0, cfg_bits};
  wire       last    = (idx + 4'd1) == (nbits + {3'b0, ack_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      nbits   <= 4'd8;
      idx     <= '0;
      ack_q   <= 1'b0;
      sh      <= '0;
      rx_data <= '0;
      irq     <= 1'b0;
      busy    <= 1'b0;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else if (launch) begin
      st      <= S_LOW;
      cnt     <= '0;
      nbits   <= len;
      ack_q   <= cfg_ack_en;
      idx     <= '0;
      sh      <= '0;
      scl_low <= 1'b1;
      busy    <= 1'b1;
      irq     <= 1'b0;
    end else begin
      case (st)
        S_WAIT: begin
          if (stop_req) begin
            st      <= S_STPA;
            cnt     <= '0;
            sda_low <= 1'b1;
            irq     <= 1'b0;
          end
        end
        S_LOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == '0) sda_low <= (idx == nbits);
          if (cnt_end) begin
            cnt     <= '0;
            scl_low <= 1'b0;
            st      <= S_HIGH;
            if (idx < nbits) sh <= {sh[6:0], sda_in};
          end
        end
        S_HIGH: begin
          cnt <= cnt + 1'b1;
          if (cnt_end) begin
            cnt     <= '0;
            idx     <= idx + 4'd1;
            scl_low <= 1'b1;
            if (last) begin
              st      <= S_WAIT;
              irq     <= 1'b1;
              rx_data <= sh;
            end else begin
              st <= S_LOW;
            end
          end
        end
        S_STPA: begin
          cnt <= cnt + 1'b1;
          if (cnt_end) begin
            cnt     <= '0;
            scl_low <= 1'b0;
            st      <= S_STPB;
          end
        end
        S_STPB: begin
          cnt <= cnt + 1'b1;
          if (cnt_end) begin
            cnt     <= '0;
            sda_low <= 1'b0;
            busy    <= 1'b0;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_mrx_engine_chk.sv
module i2c_mrx_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_strobe,
  input logic stop_req,
  input logic irq,
  input logic busy,
  input logic scl_low,
  input logic sda_low
);

  assert_sda_moves_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_low != $past(sda_low)) && busy |-> scl_low && $past(scl_low));

  assert_irq_scl_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scl_low);

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !rd_strobe && !stop_req |=> irq);

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !scl_low && !sda_low);

  assert_scl_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low |-> busy);

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_low && !irq);

endmodule

bind i2c_mrx_engine i2c_mrx_engine_chk u_chk (.*);

// File: tb/sim_i2c_mrx_engine.sv
module sim_i2c_mrx_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_strobe = 1'b0;
  logic stop_req = 1'b0;
  logic [2:0] cfg_bits = 3'd0;
  logic cfg_ack_en = 1'b0;
  logic sda_in;
  logic [7:0] rx_data;
  logic irq, busy, scl_low, sda_low;

  int tests = 0;
  int fails = 0;
  int rises_total = 0;
  int base = 0;
  int n_exp = 8;
  int val_exp = 0;
  bit tracking = 1'b0;
  bit prev_scl = 1'b0;
  bit prev_busy = 1'b0;
  int run = 0;
  bit last_line = 1'b1;
  logic slave_bit;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_mrx_engine #(.HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .stop_req(stop_req),
    .cfg_bits(cfg_bits), .cfg_ack_en(cfg_ack_en), .sda_in(sda_in),
    .rx_data(rx_data), .irq(irq), .busy(busy), .scl_low(scl_low), .sda_low(sda_low)
  );

  always_comb begin
    int k;
    k = rises_total - base;
    if (k < n_exp) slave_bit = val_exp[n_exp - 1 - k];
    else slave_bit = 1'b1;
  end
  assign sda_in = slave_bit & ~sda_low;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_scl && !scl_low) begin
        int k;
        k = rises_total - base;
        last_line = sda_in;
        if (tracking) begin
          if (k < n_exp) chk(sda_low == 1'b0, "R4 data bit released", sda_low, 0);
          else if (k == n_exp) chk(sda_low && !sda_in, "R4 ack drives low", sda_in, 0);
          if (k > 0) chk(run == HALF, "R7 low period", run, HALF);
        end
        rises_total++;
        run = 1;
      end else if (!prev_scl && scl_low) begin
        if (prev_busy) chk(run == HALF, "R7 high period", run, HALF);
        run = 1;
      end else begin
        run++;
      end
      prev_scl = scl_low;
      prev_busy = busy;
    end
  end

  task automatic xfer(input int cfg, input bit ack, input int val, input bit poke);
    int n;
    int w;
    n = (cfg == 0) ? 8 : cfg;
    @(negedge clk);
    cfg_bits = 3'(cfg);
    cfg_ack_en = ack;
    n_exp = n;
    val_exp = val;
    base = rises_total;
    tracking = 1'b1;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    chk(!irq && busy && scl_low, "R9 launch state", {irq, busy, scl_low}, 3);
    if (poke) begin
      repeat (5) @(negedge clk);
      rd_strobe = 1'b1;
      stop_req = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      stop_req = 1'b0;
    end
    w = 0;
    while (!irq && w < 2000) begin
      @(negedge clk);
      w++;
    end
    chk(rx_data == 8'(val), "R3 received word", rx_data, val);
    chk(rises_total - base == n + int'(ack), "R2 pulse count", rises_total - base, n + int'(ack));
    tracking = 1'b0;
    repeat (4) @(negedge clk);
    chk(irq && scl_low && busy, "R5 hold after word", {irq, scl_low, busy}, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_low && !sda_low && !busy && !irq && rx_data == 0, "R1 reset state",
        {scl_low, sda_low, busy, irq}, 0);

    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !scl_low && !sda_low, "R10 stop while idle", {busy, scl_low, sda_low}, 0);

    for (int c = 0; c < 8; c++) begin
      int n;
      n = (c == 0) ? 8 : c;
      for (int v = 0; v < (1 << n); v++) begin
        xfer(c, bit'(v[0] ^ c[0]), v, 1'b0);
      end
    end

    xfer(0, 1'b1, 8'h5A, 1'b1);
    xfer(0, 1'b0, 8'hC3, 1'b1);

    xfer(0, 1'b0, 8'hA5, 1'b0);
    xfer(1, 1'b0, 1, 1'b0);
    chk(last_line == 1'b1, "R4 NACK bit high", last_line, 1);

    @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk(sda_low && scl_low && !irq && busy, "R8 stop SDA low first", {sda_low, scl_low, irq, busy}, 13);
    repeat (HALF) @(negedge clk);
    chk(sda_low && !scl_low && busy, "R8 SCL released", {sda_low, scl_low, busy}, 5);
    repeat (HALF - 1) @(negedge clk);
    chk(sda_low && busy, "R8 SDA still low", {sda_low, busy}, 3);
    @(negedge clk);
    chk(!sda_low && !scl_low && !busy, "R8 stop complete", {sda_low, scl_low, busy}, 0);
    repeat (4) @(negedge clk);
    chk(!sda_low && !scl_low && !busy && !irq, "R9 idle after stop", {sda_low, scl_low, busy, irq}, 0);

    xfer(3, 1'b1, 5, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule